// File: doc/BRIEF.md
# SPI Status Flags and Match Compare

This block holds the flag and status logic of a 16-bit serial peripheral controller, as a small CPU register bus sees it. When the shift engine finishes a transfer, the block loads the received word into a 16-bit receive buffer and raises a receive-full flag. The cycle after the load, it compares the buffer against a programmable 16-bit match value and raises a match flag if the two are equal. The block also tracks transmit-empty and mode-fault.

Each flag that software clears has its own two-step sequence. Software first reads the status register while the flag is set, which arms the flag. The second step is an access that depends on the flag: a data read, a write of one to the match bit, or a write to the divisor register. A new setting event that arrives before the second step cancels the armed state.

A 3-bit divisor select picks a power-of-two divisor from 2 to 256. The block produces a single-cycle bit-clock enable every N system clocks. Writing the divisor register restarts the count.

Top module: `spi_flag_unit`

## Requirements
- R1: With divisor select s (0 to 7), bitClkEn is a single-cycle pulse with a period of exactly 2^(s+1) clocks, so select 0 gives 2, select 3 gives 16 and select 7 gives 256.
- R2: The register addresses are 0 for status, 1 for receive data, 2 for match value and 3 for divisor select (bits 2:0). A read returns its value in the same cycle as busRd. In the status byte, bit 7 is receive-full, bit 6 is match, bit 5 is transmit-empty and bit 4 is mode-fault. Bits 3:0 and all upper bits read 0.
- R3: After reset the status reads 0x20, and the divisor select, match value and receive buffer read 0.
- R4: A cycle with xferDone high loads xferData into the receive buffer and sets receive-full at that clock edge.
- R5: Receive-full clears only when a status read sees it set and a data read (address 1) follows. A data read without that earlier status read leaves the flag set.
- R6: The match flag sets one clock after the receive buffer is loaded, if the new buffer value equals the match value. It is not yet set in the first cycle that receive-full is visible, and a word that differs does not set it.
- R7: The match flag clears only when a status read sees it set and a status write with bit 6 equal to 1 follows. That write alone, with no earlier read, leaves the flag set.
- R8: A status write has no effect on any flag other than the match-clear step in R7.
- R9: A new setting event for a flag (a transfer, a match or a mode fault) between the arming read and the second step cancels the arming, so the second step then leaves the flag set.
- R10: When xferDone and a clearing data read fall in the same cycle, receive-full stays set.
- R11: txWrite clears transmit-empty at the next edge, and txLoad sets it. If both are high in the same cycle, txLoad wins.
- R12: modeFaultIn sets mode-fault. It clears only when a status read sees it set and a write to the divisor register (address 3) follows.
- R13: Any write to the divisor register restarts the count, so the first enable after the write comes exactly 2^(s+1) clocks later. The written select reads back at address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busRd | input | 1 | Register read strobe |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 2 | Register address |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, valid while busRd is high |
| xferDone | input | 1 | Transfer complete strobe from the shift engine |
| xferData | input | 16 | Received word, valid with xferDone |
| txWrite | input | 1 | Transmit buffer written strobe |
| txLoad | input | 1 | Shift engine took the transmit word |
| modeFaultIn | input | 1 | Mode-fault event |
| bitClkEn | output | 1 | Single-cycle bit-clock enable |

## Verification
The bench builds the block with its defaults: a 16-bit data width and a 3-bit select. With these values the full divisor range, including the 256-clock extreme, fits within a few hundred cycles. The receive and match words are compared at full width, so a single differing bit is enough to test the mismatch case. The bench drives every clearing sequence both complete and incomplete, and places interrupting events between the two steps.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;

  typedef enum logic [1:0] {
    ADDR_STATUS = 2'd0,
    ADDR_DATA   = 2'd1,
    ADDR_MATCH  = 2'd2,
    ADDR_DIV    = 2'd3
  } regAddr_t;

  localparam int STAT_RX_BIT    = 7;
  localparam int STAT_MATCH_BIT = 6;
  localparam int STAT_TX_BIT    = 5;
  localparam int STAT_MF_BIT    = 4;
  localparam logic [7:0] STATUS_RESET = 8'h20;

  // strobes from control to datapath
  typedef struct packed {
    logic loadRx;
    logic writeMatch;
    logic writeSel;
  } dpStrobe_t;

endpackage

// File: rtl/spi_flag_bit.sv
module spi_flag_bit #(
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic setEvt,
  input  logic armRead,
  input  logic clearAct,
  output logic flag
);

  logic armed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flag  <= RESET_VAL;
      armed <= 1'b0;
    end else if (setEvt) begin
      flag  <= 1'b1;
      armed <= 1'b0;
    end else if (armed && clearAct) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else if (armRead && flag) begin
      armed <= 1'b1;
    end
  end

  // R9: the armed state never outlives the flag
  p_arm_needs_flag_r9: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> flag);

  // R10: a setting event wins over a clearing action
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    setEvt |=> (flag && !armed));

  // R5: no clear without an armed read
  p_no_clear_unarmed_r5: assert property (@(posedge clk) disable iff (!rstN)
    (flag && !armed) |=> flag);

endmodule

// File: rtl/spi_flag_ctrl.sv
module spi_flag_ctrl
  import spi_flag_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busRd,
  input  logic       busWr,
  input  logic [1:0] busAddr,
  input  logic       wrMatchBit,
  input  logic       xferDone,
  input  logic       txWrite,
  input  logic       txLoad,
  input  logic       modeFaultIn,
  input  logic       matchEvt,
  output dpStrobe_t  strobe,
  output logic [7:0] statusByte
);

  logic rdStatus, rdData, wrStatus, wrMatch, wrDiv;
  logic rxFull, matchFlag, modeFault, txEmpty;

  always_comb begin
    rdStatus = busRd && (busAddr == ADDR_STATUS);
    rdData   = busRd && (busAddr == ADDR_DATA);
    wrStatus = busWr && (busAddr == ADDR_STATUS);
    wrMatch  = busWr && (busAddr == ADDR_MATCH);
    wrDiv    = busWr && (busAddr == ADDR_DIV);
  end

  always_comb begin
    strobe.loadRx     = xferDone;
    strobe.writeMatch = wrMatch;
    strobe.writeSel   = wrDiv;
  end

  spi_flag_bit #(.RESET_VAL(1'b0)) i_rxFlag (
    .clk(clk), .rstN(rstN), .setEvt(xferDone), .armRead(rdStatus),
    .clearAct(rdData), .flag(rxFull));

  spi_flag_bit #(.RESET_VAL(1'b0)) i_matchFlag (
    .clk(clk), .rstN(rstN), .setEvt(matchEvt), .armRead(rdStatus),
    .clearAct(wrStatus && wrMatchBit), .flag(matchFlag));

  spi_flag_bit #(.RESET_VAL(1'b0)) i_mfFlag (
    .clk(clk), .rstN(rstN), .setEvt(modeFaultIn), .armRead(rdStatus),
    .clearAct(wrDiv), .flag(modeFault));

  always_ff @(posedge clk) begin
    if (!rstN)        txEmpty <= STATUS_RESET[STAT_TX_BIT];
    else if (txLoad)  txEmpty <= 1'b1;
    else if (txWrite) txEmpty <= 1'b0;
  end

  always_comb begin
    statusByte = 8'h00;
    statusByte[STAT_RX_BIT]    = rxFull;
    statusByte[STAT_MATCH_BIT] = matchFlag;
    statusByte[STAT_TX_BIT]    = txEmpty;
    statusByte[STAT_MF_BIT]    = modeFault;
  end

  p_rx_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> rxFull);

  p_tx_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    (txWrite && !txLoad) |=> !txEmpty);

  p_tx_set_r11: assert property (@(posedge clk) disable iff (!rstN)
    txLoad |=> txEmpty);

  p_mf_set_r12: assert property (@(posedge clk) disable iff (!rstN)
    modeFaultIn |=> modeFault);

  p_status_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrStatus && !xferDone && !modeFaultIn && !txWrite && !txLoad && !busRd)
      |=> ($stable(rxFull) && $stable(modeFault) && $stable(txEmpty)));

endmodule

// File: rtl/spi_flag_dp.sv
module spi_flag_dp
  import spi_flag_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] xferData,
  input  logic              busRd,
  input  logic [1:0]        busAddr,
  input  logic [7:0]        statusByte,
  output logic              matchEvt,
  output logic [DATA_W-1:0] busRdata,
  output logic              bitClkEn
);

  localparam int CNT_W = 2 ** SEL_W;

  logic [DATA_W-1:0] rxBuf, matchReg;
  logic [SEL_W-1:0]  divSel;
  logic              loadedQ;
  logic [CNT_W-1:0]  cnt, limit;
  logic [CNT_W:0]    limitWide;
  logic [SEL_W:0]    shiftAmt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxBuf    <= '0;
      matchReg <= '0;
      divSel   <= '0;
      loadedQ  <= 1'b0;
    end else begin
      loadedQ <= strobe.loadRx;
      if (strobe.loadRx)     rxBuf    <= xferData;
      if (strobe.writeMatch) matchReg <= busWdata;
      if (strobe.writeSel)   divSel   <= busWdata[SEL_W-1:0];
    end
  end

  assign matchEvt = loadedQ && (rxBuf == matchReg);

  always_comb begin
    shiftAmt  = {1'b0, divSel} + 1'b1;
    limitWide = (CNT_W+1)'(1) << shiftAmt;
    limit     = CNT_W'(limitWide - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.writeSel) cnt <= '0;
    else if (cnt == limit)        cnt <= '0;
    else                          cnt <= cnt + 1'b1;
  end

  assign bitClkEn = (cnt == limit);

  always_comb begin
    busRdata = '0;
    if (busRd) begin
      unique case (regAddr_t'(busAddr))
        ADDR_STATUS: busRdata[7:0] = statusByte;
        ADDR_DATA:   busRdata = rxBuf;
        ADDR_MATCH:  busRdata = matchReg;
        ADDR_DIV:    busRdata[SEL_W-1:0] = divSel;
      endcase
    end
  end

  p_enable_single_r1: assert property (@(posedge clk) disable iff (!rstN)
    bitClkEn |=> !bitClkEn);

  p_restart_r13: assert property (@(posedge clk) disable iff (!rstN)
    strobe.writeSel |=> (cnt == '0));

  p_match_after_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    matchEvt |-> $past(strobe.loadRx));

  p_status_low_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == ADDR_STATUS) |-> (busRdata[3:0] == 4'h0));

endmodule

// File: rtl/spi_flag_unit.sv
module spi_flag_unit
  import spi_flag_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              xferDone,
  input  logic [DATA_W-1:0] xferData,
  input  logic              txWrite,
  input  logic              txLoad,
  input  logic              modeFaultIn,
  output logic              bitClkEn
);

  dpStrobe_t  strobe;
  logic [7:0] statusByte;
  logic       matchEvt;

  spi_flag_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .busRd(busRd), .busWr(busWr), .busAddr(busAddr),
    .wrMatchBit(busWdata[STAT_MATCH_BIT]), .xferDone(xferDone),
    .txWrite(txWrite), .txLoad(txLoad), .modeFaultIn(modeFaultIn),
    .matchEvt(matchEvt), .strobe(strobe), .statusByte(statusByte));

  spi_flag_dp #(.DATA_W(DATA_W), .SEL_W(SEL_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .xferData(xferData), .busRd(busRd), .busAddr(busAddr),
    .statusByte(statusByte), .matchEvt(matchEvt), .busRdata(busRdata),
    .bitClkEn(bitClkEn));

endmodule

// File: tb/test_spi_flag_unit.sv
module test_spi_flag_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busRd = 1'b0, busWr = 1'b0;
  logic [1:0]  busAddr = '0;
  logic [15:0] busWdata = '0, busRdata;
  logic        xferDone = 1'b0;
  logic [15:0] xferData = '0;
  logic        txWrite = 1'b0, txLoad = 1'b0, modeFaultIn = 1'b0;
  logic        bitClkEn;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] expQ[$];
  string       tagQ[$];

  always #2.5 clk = ~clk;

  spi_flag_unit i_spi_flag_unit (
    .clk(clk), .rstN(rstN), .busRd(busRd), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .xferDone(xferDone),
    .xferData(xferData), .txWrite(txWrite), .txLoad(txLoad),
    .modeFaultIn(modeFaultIn), .bitClkEn(bitClkEn));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: pops an expected read value on each read cycle
  always @(negedge clk) begin
    if (busRd && rstN) begin
      if (expQ.size() == 0) begin
        check(1'b0, "scoreboard underflow", 0, 1);
      end else begin
        logic [15:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checks++;
        if (busRdata !== e) begin
          fails++;
          $display("FAIL %s actual 0x%h expected 0x%h", t, busRdata, e);
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic busRead(input logic [1:0] a, input logic [15:0] e, input string t);
    expQ.push_back(e);
    tagQ.push_back(t);
    busAddr = a;
    busRd   = 1'b1;
    tick();
    busRd = 1'b0;
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [15:0] d);
    busAddr  = a;
    busWdata = d;
    busWr    = 1'b1;
    tick();
    busWr = 1'b0;
  endtask

  task automatic xfer(input logic [15:0] d);
    xferData = d;
    xferDone = 1'b1;
    tick();
    xferDone = 1'b0;
  endtask

  task automatic measureDiv(input logic [2:0] s, input int expN, input string t);
    int n;
    busWrite(2'd3, {13'd0, s});
    n = 1;
    @(negedge clk);
    while (!bitClkEn) begin
      @(negedge clk);
      n++;
    end
    check(n == expN, {t, " first enable after write"}, n, expN);
    n = 1;
    @(negedge clk);
    while (!bitClkEn) begin
      @(negedge clk);
      n++;
    end
    check(n == expN, {t, " enable period"}, n, expN);
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();

    // R3 reset values
    busRead(2'd0, 16'h0020, "R3 status after reset");
    busRead(2'd3, 16'h0000, "R3 divisor after reset");
    busRead(2'd2, 16'h0000, "R3 match after reset");
    busRead(2'd1, 16'h0000, "R3 rx buffer after reset");

    // R4, R5 full clear sequence
    xfer(16'h1234);
    busRead(2'd0, 16'h00A0, "R4 receive-full set");
    busRead(2'd1, 16'h1234, "R4 received word");
    busRead(2'd0, 16'h0020, "R5 cleared by read sequence");

    // R5 data read without arming, R9 arm cancelled by new transfer
    xfer(16'h5555);
    busRead(2'd1, 16'h5555, "R5 unarmed data read");
    busRead(2'd0, 16'h00A0, "R5 flag kept without arming");
    xfer(16'h0101);
    busRead(2'd1, 16'h0101, "R9 data read after cancel");
    busRead(2'd0, 16'h00A0, "R9 flag kept after cancel");

    // R10 transfer and clearing read in same cycle
    expQ.push_back(16'h0101);
    tagQ.push_back("R10 read during transfer");
    busAddr = 2'd1; busRd = 1'b1;
    xferData = 16'h0202; xferDone = 1'b1;
    tick();
    busRd = 1'b0; xferDone = 1'b0;
    busRead(2'd0, 16'h00A0, "R10 receive-full stays set");
    busRead(2'd1, 16'h0202, "R10 new word");
    busRead(2'd0, 16'h0020, "R10 later clear");

    // R6, R7 match
    busWrite(2'd2, 16'hBEEF);
    busRead(2'd2, 16'hBEEF, "R2 match readback");
    xfer(16'hBEEF);
    busRead(2'd0, 16'h00A0, "R6 match not yet set");
    busRead(2'd0, 16'h00E0, "R6 match set");
    xfer(16'hBEEF);
    tick();
    busWrite(2'd0, 16'h0040);
    busRead(2'd0, 16'h00E0, "R7 unarmed write keeps match");
    busWrite(2'd0, 16'h0040);
    busRead(2'd0, 16'h00A0, "R7 match cleared");
    busRead(2'd1, 16'hBEEF, "R7 data read");
    busRead(2'd0, 16'h0020, "R7 receive-full cleared");
    xfer(16'hBEEE);
    tick();
    busRead(2'd0, 16'h00A0, "R6 mismatch no match");
    busRead(2'd1, 16'hBEEE, "R6 data");
    busRead(2'd0, 16'h0020, "R6 cleared");

    // R9 match arm cancelled by a new match
    xfer(16'hBEEF);
    tick();
    busRead(2'd0, 16'h00E0, "R9 match armed");
    xfer(16'hBEEF);
    tick();
    busWrite(2'd0, 16'h0040);
    busRead(2'd0, 16'h00E0, "R9 match kept after new match");
    busWrite(2'd0, 16'h0040);
    busRead(2'd1, 16'hBEEF, "R9 data");
    busRead(2'd0, 16'h0020, "R9 both cleared");

    // R8 status write without match bit
    busWrite(2'd0, 16'hFFBF);
    busRead(2'd0, 16'h0020, "R8 status write ignored");
    xfer(16'h0007);
    busRead(2'd0, 16'h00A0, "R8 arming read");
    busWrite(2'd0, 16'h00BF);
    busRead(2'd0, 16'h00A0, "R8 write leaves receive-full");
    busRead(2'd1, 16'h0007, "R8 data");

    // R11 transmit-empty
    txWrite = 1'b1; tick(); txWrite = 1'b0;
    busRead(2'd0, 16'h0000, "R11 tx-empty cleared");
    txLoad = 1'b1; tick(); txLoad = 1'b0;
    busRead(2'd0, 16'h0020, "R11 tx-empty set");
    txWrite = 1'b1; txLoad = 1'b1; tick(); txWrite = 1'b0; txLoad = 1'b0;
    busRead(2'd0, 16'h0020, "R11 load wins");

    // R12 mode fault
    modeFaultIn = 1'b1; tick(); modeFaultIn = 1'b0;
    busWrite(2'd3, 16'h0000);
    busRead(2'd0, 16'h0030, "R12 unarmed write keeps fault");
    busWrite(2'd3, 16'h0000);
    busRead(2'd0, 16'h0020, "R12 fault cleared");
    modeFaultIn = 1'b1; tick(); modeFaultIn = 1'b0;
    busRead(2'd0, 16'h0030, "R12 armed");
    modeFaultIn = 1'b1; tick(); modeFaultIn = 1'b0;
    busWrite(2'd3, 16'h0000);
    busRead(2'd0, 16'h0030, "R9 fault arm cancelled");
    busWrite(2'd3, 16'h0000);
    busRead(2'd0, 16'h0020, "R12 fault cleared after rearm");

    // R1, R13 divisor
    measureDiv(3'd0, 2, "R1 select 0");
    measureDiv(3'd3, 16, "R1 select 3");
    busRead(2'd3, 16'h0003, "R13 select readback");
    measureDiv(3'd7, 256, "R1 select 7");
    repeat (100) tick();
    measureDiv(3'd7, 256, "R13 restart on rewrite");

    tick();
    check(expQ.size() == 0, "scoreboard drained", expQ.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule